// File: doc/BRIEF.md
# SPI Page-Flash Command Sequencer

This block drives a serial data-flash organised in pages over a four-wire SPI link. A client hands it one request at a time. The request carries an opcode, a page number, a byte offset inside the page, a data length and a direction bit. The sequencer then frames the whole transaction on its own. It holds chip-select high for a short gap so that the device's command decoder restarts. It then pulls chip-select low and shifts out four header bytes that carry the opcode and the packed address. Next come as many dummy bytes as the opcode calls for, and then the data phase. In the data phase it either collects bytes from the device and strobes each one to the client, or requests bytes from the client one at a time and shifts them out.

Some opcodes leave the device working internally: page programs, erases, memory-to-buffer transfers, compares and auto-rewrites. After such an opcode the sequencer releases chip-select and starts polling. Each poll is a separate two-byte frame: the status-read opcode followed by one dummy byte. Polling repeats until the device reports ready, and the final status byte is handed back to the client, compare-result bit included. The SPI engine inside runs in mode 0, shifts MSB first, and derives its serial clock from the system clock through a divider parameter.

Top module: `sflash_cmd_seq`

## Requirements
- R1: After synchronous reset, spi_cs_n is 1, spi_sclk is 0, and busy, req_ack, rd_valid, wr_ready and stat_valid are all 0.
- R2: Before every frame goes low, spi_cs_n is held high for at least CS_GAP system clock cycles. This covers the command frame and every status poll frame.
- R3: Each command frame starts with four header bytes: the opcode, then page >> (16 − PAGE_BITS), then ((page << (PAGE_BITS − 8)) + (offset >> 8)) mod 256, then offset mod 256. For opcodes 0x84 and 0x87 the page field is replaced by 0.
- R4: Dummy bytes follow the header: 1 for opcode 0x0B, 4 for opcode 0xE8, 1 for opcodes 0xD2, 0xD4 and 0xD6, and 0 for every other opcode.
- R5: With req_write = 0, exactly req_len bytes are read after the dummy bytes. Each byte is sampled from spi_miso on rising spi_sclk, MSB first, and is presented on rd_data with a one-cycle rd_valid pulse.
- R6: With req_write = 1, wr_ready pulses exactly req_len times. The wr_data value present in each pulse cycle is shifted out on spi_mosi, MSB first, as the next data byte.
- R7: A req_len of 0 produces a frame of only the header and dummy bytes, so the frame length is 4 + dummies + req_len bytes. spi_cs_n rises after the last byte.
- R8: After opcodes 0x81, 0x50, 0x7C, 0x82, 0x83, 0x85, 0x86, 0x88, 0x89, 0x53, 0x55, 0x58, 0x59, 0x60 and 0x61, the block issues status frames of two bytes each (0xD7, then one dummy byte). It repeats them until bit 7 of the returned byte is 1. That final byte appears on stat_data with a single stat_valid pulse. No other opcode produces a status frame.
- R9: SPI mode 0: spi_sclk is low whenever spi_cs_n is high, and its period is SCLK_DIV system clock cycles.
- R10: A request is taken only while idle and is answered by a one-cycle req_ack. busy is high from req_ack until the last frame of the command ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_opcode | input | 8 | Command opcode |
| req_page | input | 24-PAGE_BITS | Page number |
| req_offset | input | PAGE_BITS | Byte offset inside the page |
| req_len | input | LEN_W | Number of data bytes after header and dummies |
| req_write | input | 1 | 1 = data phase writes, 0 = reads |
| req_ack | output | 1 | One-cycle acceptance pulse |
| busy | output | 1 | Command in progress |
| wr_data | input | 8 | Write byte, taken when wr_ready is high |
| wr_ready | output | 1 | Write byte accepted this cycle |
| rd_data | output | 8 | Read byte |
| rd_valid | output | 1 | rd_data valid this cycle |
| stat_data | output | 8 | Final status byte of a poll |
| stat_valid | output | 1 | stat_data valid this cycle |
| spi_cs_n | output | 1 | Chip-select, active low |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the device |
| spi_miso | input | 1 | Serial data from the device |

## Verification
A corrupted byte index or dummy counter in the sequencer shows up as a wrong frame length or a shifted data stream at the SPI pins, within the same frame. A stuck poll decision shows up as an extra or missing 0xD7 frame or a wrong stat_data value, one poll interval after the command frame closes. A slip in the bit counter of the shifter corrupts the very first header byte. The sweep crosses every opcode class with lengths 0, 1 and 3 and with 0, 1 or 2 not-ready replies, so each of these faults reaches a byte comparison.

// File: rtl/sfc_pkg.sv
`timescale 1ns/1ps
package sfc_pkg;

    localparam logic [7:0] OP_STATUS_RD = 8'hD7;
    localparam int         RDY_BIT      = 7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GAP,
        ST_HDR,
        ST_DUMMY,
        ST_DATA,
        ST_PGAP,
        ST_POP,
        ST_PRD
    } fsm_e;

    typedef struct packed {
        logic [7:0]  opcode;
        logic [23:0] addr;
        logic        write;
        logic        poll;
        logic [2:0]  ndummy;
    } cmd_t;

    function automatic logic [2:0] dummy_count(input logic [7:0] op);
        case (op)
            8'h0B, 8'hD2, 8'hD4, 8'hD6: dummy_count = 3'd1;
            8'hE8:                      dummy_count = 3'd4;
            default:                    dummy_count = 3'd0;
        endcase
    endfunction

    function automatic logic needs_poll(input logic [7:0] op);
        case (op)
            8'h81, 8'h50, 8'h7C, 8'h82, 8'h83, 8'h85, 8'h86, 8'h88,
            8'h89, 8'h53, 8'h55, 8'h58, 8'h59, 8'h60, 8'h61:
                needs_poll = 1'b1;
            default:
                needs_poll = 1'b0;
        endcase
    endfunction

    function automatic logic zero_page(input logic [7:0] op);
        zero_page = (op == 8'h84) || (op == 8'h87);
    endfunction

endpackage

// File: rtl/sfc_spi_shifter.sv
`timescale 1ns/1ps
module sfc_spi_shifter #(
    parameter int SCLK_DIV = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [7:0] tx,
    output logic       busy,
    output logic       done,
    output logic [7:0] rx,
    output logic       sclk,
    output logic       mosi,
    input  logic       miso
);
    localparam int HALF  = (SCLK_DIV < 2) ? 1 : SCLK_DIV / 2;
    localparam int CNT_W = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CNT_W-1:0] div_cnt;
    logic [2:0]       bit_idx;
    logic [7:0]       sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            done    <= 1'b0;
            rx      <= '0;
            sclk    <= 1'b0;
            sr      <= '0;
            div_cnt <= '0;
            bit_idx <= '0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy    <= 1'b1;
                    sr      <= tx;
                    div_cnt <= '0;
                    bit_idx <= '0;
                    sclk    <= 1'b0;
                end
            end else if (div_cnt == CNT_W'(HALF - 1)) begin
                div_cnt <= '0;
                if (!sclk) begin
                    sclk <= 1'b1;
                    rx   <= {rx[6:0], miso};
                end else begin
                    sclk <= 1'b0;
                    if (bit_idx == 3'd7) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end else begin
                        bit_idx <= bit_idx + 3'd1;
                        sr      <= {sr[6:0], 1'b0};
                    end
                end
            end else begin
                div_cnt <= div_cnt + CNT_W'(1);
            end
        end
    end

    assign mosi = sr[7];

    AST_SCLK_LOW_IDLE: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !sclk);                                   // R9
    AST_DONE_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        done |-> ($fell(sclk) && !busy));                   // R9

endmodule

// File: rtl/sfc_frame_ctrl.sv
`timescale 1ns/1ps
module sfc_frame_ctrl
    import sfc_pkg::*;
#(
    parameter int PAGE_BITS = 9,
    parameter int LEN_W     = 8,
    parameter int CS_GAP    = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    input  logic [7:0]            req_opcode,
    input  logic [23-PAGE_BITS:0] req_page,
    input  logic [PAGE_BITS-1:0]  req_offset,
    input  logic [LEN_W-1:0]      req_len,
    input  logic                  req_write,
    output logic                  req_ack,
    output logic                  busy,
    input  logic [7:0]            wr_data,
    output logic                  wr_ready,
    output logic [7:0]            rd_data,
    output logic                  rd_valid,
    output logic [7:0]            stat_data,
    output logic                  stat_valid,
    output logic                  cs_n,
    output logic                  sh_start,
    output logic [7:0]            sh_tx,
    input  logic                  sh_done,
    input  logic [7:0]            sh_rx
);
    localparam int GAP_N = (CS_GAP < 1) ? 1 : CS_GAP;
    localparam int GAP_W = $clog2(GAP_N + 1);

    fsm_e             state;
    cmd_t             cmd;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] len_left;
    logic [1:0]       idx;
    logic [2:0]       dum_left;
    logic [GAP_W-1:0] gap_cnt;
    logic             launch;
    logic [7:0]       hdr_byte;
    logic [23:0]      new_addr;

    assign new_addr = zero_page(req_opcode) ? 24'(req_offset)
                    : ((24'(req_page) << PAGE_BITS) | 24'(req_offset));

    always_comb begin
        case (idx)
            2'd0:    hdr_byte = cmd.opcode;
            2'd1:    hdr_byte = cmd.addr[23:16];
            2'd2:    hdr_byte = cmd.addr[15:8];
            default: hdr_byte = cmd.addr[7:0];
        endcase
        case (state)
            ST_HDR:  sh_tx = hdr_byte;
            ST_DATA: sh_tx = cmd.write ? wr_data : 8'h00;
            ST_POP:  sh_tx = OP_STATUS_RD;
            default: sh_tx = 8'h00;
        endcase
    end

    assign sh_start = launch;
    assign wr_ready = launch && (state == ST_DATA) && cmd.write;
    assign busy     = (state != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            cmd        <= '0;
            len_q      <= '0;
            len_left   <= '0;
            idx        <= '0;
            dum_left   <= '0;
            gap_cnt    <= '0;
            launch     <= 1'b0;
            cs_n       <= 1'b1;
            req_ack    <= 1'b0;
            rd_data    <= '0;
            rd_valid   <= 1'b0;
            stat_data  <= '0;
            stat_valid <= 1'b0;
        end else begin
            req_ack    <= 1'b0;
            rd_valid   <= 1'b0;
            stat_valid <= 1'b0;
            launch     <= 1'b0;
            case (state)
                ST_IDLE: if (req_valid) begin
                    cmd.opcode <= req_opcode;
                    cmd.addr   <= new_addr;
                    cmd.write  <= req_write;
                    cmd.poll   <= needs_poll(req_opcode);
                    cmd.ndummy <= dummy_count(req_opcode);
                    len_q      <= req_len;
                    req_ack    <= 1'b1;
                    gap_cnt    <= '0;
                    state      <= ST_GAP;
                end
                ST_GAP, ST_PGAP: begin
                    if (gap_cnt == GAP_W'(GAP_N - 1)) begin
                        cs_n   <= 1'b0;
                        idx    <= '0;
                        launch <= 1'b1;
                        state  <= (state == ST_GAP) ? ST_HDR : ST_POP;
                    end else begin
                        gap_cnt <= gap_cnt + GAP_W'(1);
                    end
                end
                ST_HDR: if (sh_done) begin
                    if (idx != 2'd3) begin
                        idx    <= idx + 2'd1;
                        launch <= 1'b1;
                    end else if (cmd.ndummy != 3'd0) begin
                        dum_left <= cmd.ndummy;
                        launch   <= 1'b1;
                        state    <= ST_DUMMY;
                    end else if (len_q != '0) begin
                        len_left <= len_q;
                        launch   <= 1'b1;
                        state    <= ST_DATA;
                    end else begin
                        cs_n    <= 1'b1;
                        gap_cnt <= '0;
                        state   <= cmd.poll ? ST_PGAP : ST_IDLE;
                    end
                end
                ST_DUMMY: if (sh_done) begin
                    if (dum_left != 3'd1) begin
                        dum_left <= dum_left - 3'd1;
                        launch   <= 1'b1;
                    end else if (len_q != '0) begin
                        len_left <= len_q;
                        launch   <= 1'b1;
                        state    <= ST_DATA;
                    end else begin
                        cs_n    <= 1'b1;
                        gap_cnt <= '0;
                        state   <= cmd.poll ? ST_PGAP : ST_IDLE;
                    end
                end
                ST_DATA: if (sh_done) begin
                    if (!cmd.write) begin
                        rd_data  <= sh_rx;
                        rd_valid <= 1'b1;
                    end
                    if (len_left != LEN_W'(1)) begin
                        len_left <= len_left - LEN_W'(1);
                        launch   <= 1'b1;
                    end else begin
                        cs_n    <= 1'b1;
                        gap_cnt <= '0;
                        state   <= cmd.poll ? ST_PGAP : ST_IDLE;
                    end
                end
                ST_POP: if (sh_done) begin
                    launch <= 1'b1;
                    state  <= ST_PRD;
                end
                ST_PRD: if (sh_done) begin
                    cs_n    <= 1'b1;
                    gap_cnt <= '0;
                    if (sh_rx[RDY_BIT]) begin
                        stat_data  <= sh_rx;
                        stat_valid <= 1'b1;
                        state      <= ST_IDLE;
                    end else begin
                        state <= ST_PGAP;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // consecutive cycles with chip-select high, saturating
    logic [GAP_W-1:0] hi_cnt;
    always_ff @(posedge clk) begin
        if (rst)                           hi_cnt <= '0;
        else if (!cs_n)                    hi_cnt <= '0;
        else if (hi_cnt != GAP_W'(GAP_N))  hi_cnt <= hi_cnt + GAP_W'(1);
    end

    AST_CS_GAP_HELD: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && $past(cs_n)) |-> ($past(hi_cnt) >= GAP_W'(GAP_N - 1)));   // R2
    AST_WR_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
        wr_ready |-> !cs_n);                                                // R6
    AST_STAT_READY: assert property (@(posedge clk) disable iff (rst)
        stat_valid |-> stat_data[RDY_BIT]);                                 // R8
    AST_ACK_BUSY: assert property (@(posedge clk) disable iff (rst)
        req_ack |-> busy);                                                  // R10

endmodule

// File: rtl/sflash_cmd_seq.sv
`timescale 1ns/1ps
module sflash_cmd_seq #(
    parameter int SCLK_DIV  = 4,
    parameter int PAGE_BITS = 9,
    parameter int LEN_W     = 8,
    parameter int CS_GAP    = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    input  logic [7:0]            req_opcode,
    input  logic [23-PAGE_BITS:0] req_page,
    input  logic [PAGE_BITS-1:0]  req_offset,
    input  logic [LEN_W-1:0]      req_len,
    input  logic                  req_write,
    output logic                  req_ack,
    output logic                  busy,
    input  logic [7:0]            wr_data,
    output logic                  wr_ready,
    output logic [7:0]            rd_data,
    output logic                  rd_valid,
    output logic [7:0]            stat_data,
    output logic                  stat_valid,
    output logic                  spi_cs_n,
    output logic                  spi_sclk,
    output logic                  spi_mosi,
    input  logic                  spi_miso
);
    logic       sh_start;
    logic [7:0] sh_tx;
    logic       sh_busy;
    logic       sh_done;
    logic [7:0] sh_rx;

    sfc_frame_ctrl #(
        .PAGE_BITS (PAGE_BITS),
        .LEN_W     (LEN_W),
        .CS_GAP    (CS_GAP)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_opcode (req_opcode),
        .req_page   (req_page),
        .req_offset (req_offset),
        .req_len    (req_len),
        .req_write  (req_write),
        .req_ack    (req_ack),
        .busy       (busy),
        .wr_data    (wr_data),
        .wr_ready   (wr_ready),
        .rd_data    (rd_data),
        .rd_valid   (rd_valid),
        .stat_data  (stat_data),
        .stat_valid (stat_valid),
        .cs_n       (spi_cs_n),
        .sh_start   (sh_start),
        .sh_tx      (sh_tx),
        .sh_done    (sh_done),
        .sh_rx      (sh_rx)
    );

    sfc_spi_shifter #(
        .SCLK_DIV (SCLK_DIV)
    ) u_shift (
        .clk   (clk),
        .rst   (rst),
        .start (sh_start),
        .tx    (sh_tx),
        .busy  (sh_busy),
        .done  (sh_done),
        .rx    (sh_rx),
        .sclk  (spi_sclk),
        .mosi  (spi_mosi),
        .miso  (spi_miso)
    );

    AST_SCLK_IDLE_CS: assert property (@(posedge clk) disable iff (rst)
        spi_cs_n |-> !spi_sclk);                                   // R9
    AST_RD_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> !$past(spi_cs_n));                            // R5
    AST_NO_SHIFT_IDLE: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !sh_busy);                                       // R10

endmodule

// File: tb/tb_sflash_cmd_seq.sv
`timescale 1ns/1ps
module tb_sflash_cmd_seq;
    localparam int SCLK_DIV  = 4;
    localparam int PAGE_BITS = 9;
    localparam int LEN_W     = 8;
    localparam int CS_GAP    = 2;
    localparam real TCLK     = 4.0;

    logic                  clk = 1'b0;
    logic                  rst = 1'b1;
    logic                  req_valid = 1'b0;
    logic [7:0]            req_opcode = '0;
    logic [23-PAGE_BITS:0] req_page = '0;
    logic [PAGE_BITS-1:0]  req_offset = '0;
    logic [LEN_W-1:0]      req_len = '0;
    logic                  req_write = 1'b0;
    logic                  req_ack, busy, wr_ready, rd_valid, stat_valid;
    logic [7:0]            wr_data, rd_data, stat_data;
    logic                  spi_cs_n, spi_sclk, spi_mosi;
    logic                  spi_miso = 1'b0;

    always #2 clk = ~clk;

    sflash_cmd_seq #(.SCLK_DIV(SCLK_DIV), .PAGE_BITS(PAGE_BITS),
                     .LEN_W(LEN_W), .CS_GAP(CS_GAP)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_opcode(req_opcode),
        .req_page(req_page), .req_offset(req_offset), .req_len(req_len),
        .req_write(req_write), .req_ack(req_ack), .busy(busy),
        .wr_data(wr_data), .wr_ready(wr_ready), .rd_data(rd_data),
        .rd_valid(rd_valid), .stat_data(stat_data), .stat_valid(stat_valid),
        .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso));

    int n_checks = 0;
    int n_fail   = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] rpat(input int i);
        rpat = 8'((i * 37 + 11) & 255);
    endfunction
    function automatic logic [7:0] wpat(input int k);
        wpat = 8'((k * 53 + 90) & 255);
    endfunction
    function automatic int exp_dummy(input logic [7:0] op);
        if (op == 8'hE8) return 4;
        if (op == 8'h0B || op == 8'hD2 || op == 8'hD4 || op == 8'hD6) return 1;
        return 0;
    endfunction
    function automatic bit exp_poll(input logic [7:0] op);
        case (op)
            8'h81, 8'h50, 8'h7C, 8'h82, 8'h83, 8'h85, 8'h86, 8'h88,
            8'h89, 8'h53, 8'h55, 8'h58, 8'h59, 8'h60, 8'h61: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    // ---------------- flash-side model ----------------
    logic [7:0] fr_byte [8][16];
    int         fr_len  [8];
    int         fr_cnt = 0;
    int         bitc = 0, bytec = 0;
    logic [7:0] cap_sr = '0;
    bit         in_frame = 0;
    int         poll_wait = 0, polls_seen = 0;
    int         per_bad = 0, gap_bad = 0;
    realtime    t_rise = 0, t_cs_hi = 0;

    function automatic logic [7:0] resp(input int i);
        if (i == 1 && fr_cnt < 8 && fr_byte[fr_cnt][0] == 8'hD7)
            return (polls_seen < poll_wait) ? 8'h24 : 8'hA4;
        return rpat(i);
    endfunction

    always @(negedge spi_cs_n) begin
        in_frame = 1;
        bitc = 0;
        bytec = 0;
        if (fr_cnt < 8) fr_len[fr_cnt] = 0;
        if ($realtime - t_cs_hi < CS_GAP * TCLK - 0.1) gap_bad++;
        spi_miso = resp(0)[7];
    end

    always @(posedge spi_cs_n) begin
        t_cs_hi = $realtime;
        if (in_frame) begin
            if (fr_cnt < 8 && fr_byte[fr_cnt][0] == 8'hD7) polls_seen++;
            fr_cnt++;
            in_frame = 0;
        end
    end

    always @(posedge spi_sclk) if (!spi_cs_n) begin
        if (bitc > 0 && ($realtime - t_rise) != SCLK_DIV * TCLK) per_bad++;
        t_rise = $realtime;
        cap_sr = {cap_sr[6:0], spi_mosi};
        bitc++;
        if (bitc == 8) begin
            if (fr_cnt < 8 && bytec < 16) fr_byte[fr_cnt][bytec] = cap_sr;
            bytec++;
            bitc = 0;
            if (fr_cnt < 8) fr_len[fr_cnt] = bytec;
        end
    end

    always @(negedge spi_sclk) if (!spi_cs_n) begin
        spi_miso = resp(bytec)[7 - bitc];
    end

    // ---------------- client-side capture ----------------
    int         wcnt = 0, rcnt = 0, scnt = 0;
    logic [7:0] rd_buf [16];
    logic [7:0] stat_last = '0;
    assign wr_data = wpat(wcnt);

    always @(posedge clk) begin
        if (wr_ready) wcnt <= wcnt + 1;
        if (rd_valid) begin
            if (rcnt < 16) rd_buf[rcnt] <= rd_data;
            rcnt <= rcnt + 1;
        end
        if (stat_valid) begin
            stat_last <= stat_data;
            scnt <= scnt + 1;
        end
    end

    // ---------------- one command ----------------
    task automatic run(input logic [7:0] op, input int page, input int off,
                       input int len, input bit wr, input int pw);
        int dum, p, b1, b2, b3, nstat;
        @(negedge clk);
        fr_cnt = 0; polls_seen = 0; poll_wait = pw;
        wcnt = 0; rcnt = 0; scnt = 0; per_bad = 0; gap_bad = 0;
        req_opcode = op; req_page = (23-PAGE_BITS+1)'(page);
        req_offset = PAGE_BITS'(off); req_len = LEN_W'(len);
        req_write = wr; req_valid = 1'b1;
        @(negedge clk);
        while (!req_ack) @(negedge clk);
        check(busy == 1'b1, "R10 busy with ack", int'(busy), 1);
        req_valid = 1'b0;
        @(negedge clk);
        check(req_ack == 1'b0, "R10 ack one cycle", int'(req_ack), 0);
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);

        dum = exp_dummy(op);
        p   = (op == 8'h84 || op == 8'h87) ? 0 : page;
        b1  = (p >> (16 - PAGE_BITS)) & 255;
        b2  = ((p << (PAGE_BITS - 8)) + (off >> 8)) & 255;
        b3  = off & 255;
        nstat = exp_poll(op) ? pw + 1 : 0;

        check(fr_cnt == 1 + nstat, "R8 frame count", fr_cnt, 1 + nstat);
        check(fr_len[0] == 4 + dum + len, "R4 R7 frame length", fr_len[0], 4 + dum + len);
        check(fr_byte[0][0] == op, "R3 opcode byte", fr_byte[0][0], op);
        check(fr_byte[0][1] == 8'(b1), "R3 page high byte", fr_byte[0][1], b1);
        check(fr_byte[0][2] == 8'(b2), "R3 page/offset byte", fr_byte[0][2], b2);
        check(fr_byte[0][3] == 8'(b3), "R3 offset byte", fr_byte[0][3], b3);
        if (wr) begin
            check(wcnt == len, "R6 write strobes", wcnt, len);
            check(rcnt == 0, "R6 no read strobes", rcnt, 0);
            for (int j = 0; j < len; j++)
                check(fr_byte[0][4 + dum + j] == wpat(j), "R6 write byte",
                      fr_byte[0][4 + dum + j], wpat(j));
        end else begin
            check(rcnt == len, "R5 read strobes", rcnt, len);
            check(wcnt == 0, "R5 no write strobes", wcnt, 0);
            for (int j = 0; j < len; j++)
                check(rd_buf[j] == rpat(4 + dum + j), "R5 read byte",
                      rd_buf[j], rpat(4 + dum + j));
        end
        for (int k = 1; k <= nstat && k < 8; k++) begin
            check(fr_len[k] == 2, "R8 status frame length", fr_len[k], 2);
            check(fr_byte[k][0] == 8'hD7, "R8 status opcode", fr_byte[k][0], 8'hD7);
        end
        check(scnt == (nstat > 0 ? 1 : 0), "R8 status strobe count", scnt, nstat > 0 ? 1 : 0);
        if (nstat > 0)
            check(stat_last == 8'hA4, "R8 final status", stat_last, 8'hA4);
        check(per_bad == 0, "R9 sclk period", per_bad, 0);
        check(gap_bad == 0, "R2 chip-select gap", gap_bad, 0);
        check(spi_cs_n == 1'b1 && spi_sclk == 1'b0, "R9 idle lines",
              {spi_cs_n, spi_sclk}, 2'b10);
    endtask

    logic [7:0] ops [14] = '{8'h0B, 8'hE8, 8'hD2, 8'hD4, 8'hD6, 8'h84, 8'h87,
                            8'h82, 8'h83, 8'h81, 8'h50, 8'h60, 8'h53, 8'h9F};
    int lens [3] = '{0, 1, 3};

    initial begin
        repeat (3) @(negedge clk);
        check(spi_cs_n == 1'b1, "R1 cs_n reset", int'(spi_cs_n), 1);
        check(spi_sclk == 1'b0, "R1 sclk reset", int'(spi_sclk), 0);
        check({busy, req_ack, rd_valid, wr_ready, stat_valid} == 5'b0,
              "R1 strobes reset", {busy, req_ack, rd_valid, wr_ready, stat_valid}, 0);
        rst = 1'b0;
        for (int i = 0; i < 14; i++) begin
            for (int l = 0; l < 3; l++) begin
                bit wr;
                wr = (ops[i] == 8'h84 || ops[i] == 8'h87 || ops[i] == 8'h82);
                run(ops[i], (i * 4951 + lens[l] * 77) & 16'h7FFF,
                    (i * 29 + lens[l] * 101) % 264, lens[l], wr, (i + l) % 3);
            end
        end
        // extreme address fields
        run(8'h0B, 16'h7FFF, 511, 2, 1'b0, 0);
        run(8'hD2, 0, 256, 1, 1'b0, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule